// File: doc/BRIEF.md
# Octal Key Lock with Wrong-Attempt Lockout

This block is a small combination lock. A 3-bit key digit is compared against a 3-bit lock digit. Both values are decoded into eight one-hot lines, and a match exists when the same line is active on both sides. The single unlock output is high while the digits match, but only as long as the lock has not been disabled.

Each key attempt is marked by a one-cycle strobe. On every strobed mismatch, a saturating counter of consecutive wrong attempts advances. When that count reaches the programmed allowance, a sticky lockout flag is set. From then on the unlock output is held low until power-on reset. A correct strobed attempt made before lockout clears the counter, which gives back the full allowance. The allowance is a runtime input and is read at every strobe.

Top module: `keylock_top`

## Requirements
- R1: `openOut` is 1 exactly when `keyVal` equals `lockVal` and `lockedOut` is 0. It follows the inputs combinationally, for all 64 key/lock pairs.
- R2: For an allowance n from 1 to 7, the n-th consecutive strobed mismatch sets `lockedOut` on the clock edge that samples it. After n-1 mismatches, `lockedOut` is still 0.
- R3: With an allowance of 0, a single strobed mismatch sets `lockedOut`.
- R4: Once `lockedOut` is 1 it stays 1, and `openOut` stays 0, whatever keys, strobes or allowance values follow. Only reset clears it.
- R5: A strobed matching attempt before lockout clears the wrong-attempt count. After it, n further mismatches are needed to lock.
- R6: A cycle without `attemptStb` changes neither the count nor the lockout, even when the key mismatches.
- R7: Synchronous active-high `rst` clears both the lockout and the wrong-attempt count.
- R8: A new allowance applies at the next strobed attempt. If the count after a mismatch is at or above the new allowance, lockout is set.
- R9: `allowance` is an unsigned binary number with bit 2 as the most significant bit (for example, 3'b100 allows four wrong attempts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| attemptStb | input | 1 | One-cycle marker of a key attempt |
| keyVal | input | 3 | Key digit |
| lockVal | input | 3 | Lock digit |
| allowance | input | 3 | Permitted consecutive wrong attempts, MSB first |
| openOut | output | 1 | Unlock indication |
| lockedOut | output | 1 | Permanent lockout flag |

## Verification
The bound checker enforces four rules on every clock:
- `openOut` never rises on a mismatch.
- `openOut` is never high while locked.
- The lockout flag never falls outside reset.
- The lockout only rises after a strobed mismatch.

The checker cannot see how many mismatches were needed, whether a correct attempt restored the allowance, or how a mid-run allowance change was applied. Those are shown only by the bench's scenarios: the lockout sequence for each allowance, the re-arm sequence and the allowance change, all compared against its behavioural model every cycle.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  // Commands from control to the attempt counter
  typedef struct packed {
    logic clearCnt;
    logic bumpCnt;
  } cnt_cmd_t;
endpackage

// File: rtl/keylock_decoder.sv
module keylock_decoder #(
  parameter int DIGIT_W = 3,
  localparam int LINES = 1 << DIGIT_W
) (
  input  logic [DIGIT_W-1:0] digit,
  output logic [LINES-1:0]   lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (digit == DIGIT_W'(i));
  end
endmodule

// File: rtl/keylock_datapath.sv
module keylock_datapath
  import keylock_pkg::*;
#(
  parameter int DIGIT_W = 3,
  localparam int LINES = 1 << DIGIT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] keyVal,
  input  logic [DIGIT_W-1:0] lockVal,
  input  logic [DIGIT_W-1:0] allowance,
  input  cnt_cmd_t           cmd,
  output logic               match,
  output logic               limitHit
);
  logic [LINES-1:0]   keyLines;
  logic [LINES-1:0]   lockLines;
  logic [DIGIT_W-1:0] wrongCnt;
  logic [DIGIT_W-1:0] nextCnt;

  keylock_decoder #(.DIGIT_W(DIGIT_W)) u_keyDec  (.digit(keyVal),  .lines(keyLines));
  keylock_decoder #(.DIGIT_W(DIGIT_W)) u_lockDec (.digit(lockVal), .lines(lockLines));

  assign match = |(keyLines & lockLines);

  // saturating increment, never wraps
  assign nextCnt  = (&wrongCnt) ? wrongCnt : wrongCnt + DIGIT_W'(1);
  assign limitHit = (nextCnt >= allowance);

  always_ff @(posedge clk) begin
    if (rst)               wrongCnt <= '0;
    else if (cmd.clearCnt) wrongCnt <= '0;
    else if (cmd.bumpCnt)  wrongCnt <= nextCnt;
  end
endmodule

// File: rtl/keylock_control.sv
module keylock_control
  import keylock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     attemptStb,
  input  logic     match,
  input  logic     limitHit,
  output cnt_cmd_t cmd,
  output logic     openOut,
  output logic     lockedOut
);
  logic active;

  assign active       = attemptStb && !lockedOut;
  assign cmd.clearCnt = active && match;
  assign cmd.bumpCnt  = active && !match;
  assign openOut      = match && !lockedOut;

  always_ff @(posedge clk) begin
    if (rst)                                lockedOut <= 1'b0;
    else if (active && !match && limitHit)  lockedOut <= 1'b1;
  end
endmodule

// File: rtl/keylock_top.sv
module keylock_top
  import keylock_pkg::*;
#(
  parameter int DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               attemptStb,
  input  logic [DIGIT_W-1:0] keyVal,
  input  logic [DIGIT_W-1:0] lockVal,
  input  logic [DIGIT_W-1:0] allowance,
  output logic               openOut,
  output logic               lockedOut
);
  cnt_cmd_t cmd;
  logic     match;
  logic     limitHit;

  keylock_datapath #(.DIGIT_W(DIGIT_W)) u_dp (
    .clk(clk), .rst(rst), .keyVal(keyVal), .lockVal(lockVal),
    .allowance(allowance), .cmd(cmd), .match(match), .limitHit(limitHit)
  );

  keylock_control u_ctl (
    .clk(clk), .rst(rst), .attemptStb(attemptStb), .match(match),
    .limitHit(limitHit), .cmd(cmd), .openOut(openOut), .lockedOut(lockedOut)
  );
endmodule

// File: rtl/keylock_checker.sv
module keylock_checker #(
  parameter int DIGIT_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               attemptStb,
  input logic [DIGIT_W-1:0] keyVal,
  input logic [DIGIT_W-1:0] lockVal,
  input logic               openOut,
  input logic               lockedOut
);
  AST_OPEN_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    openOut |-> (keyVal == lockVal)); // R1
  AST_LOCK_BLOCKS_OPEN: assert property (@(posedge clk) disable iff (rst)
    lockedOut |-> !openOut); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lockedOut |=> lockedOut); // R4
  AST_LOCK_ON_WRONG_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!lockedOut ##1 lockedOut) |-> ($past(attemptStb) && $past(keyVal != lockVal))); // R6
endmodule

bind keylock_top keylock_checker #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk(clk), .rst(rst), .attemptStb(attemptStb), .keyVal(keyVal),
  .lockVal(lockVal), .openOut(openOut), .lockedOut(lockedOut)
);

// File: tb/keylock_top_bench.sv
module keylock_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       attemptStb = 1'b0;
  logic [2:0] keyVal = '0;
  logic [2:0] lockVal = '0;
  logic [2:0] allowance = '0;
  logic       openOut, lockedOut;

  int checks = 0;
  int fails = 0;
  int refCount = 0;
  bit refLocked = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  keylock_top u_keylock_top (
    .clk(clk), .rst(rst), .attemptStb(attemptStb), .keyVal(keyVal),
    .lockVal(lockVal), .allowance(allowance), .openOut(openOut), .lockedOut(lockedOut)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle, compare outputs before the edge, then advance the model on the edge.
  task automatic step(input string tag, input bit stb, input int k, input int l, input int n);
    @(negedge clk);
    attemptStb = stb; keyVal = 3'(k); lockVal = 3'(l); allowance = 3'(n);
    #1;
    check(tag, openOut, (k == l) && !refLocked, "openOut");
    check(tag, lockedOut, refLocked, "lockedOut");
    @(posedge clk);
    if (stb && !refLocked) begin
      if (k == l) refCount = 0;
      else begin
        if (refCount < 7) refCount++;
        if (refCount >= n) refLocked = 1'b1;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; attemptStb = 1'b0;
    repeat (2) @(posedge clk);
    refCount = 0; refLocked = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R7: reset state
    step("R7", 0, 1, 2, 7);
    // R1: all 64 pairs, R6: mismatches without strobe change nothing
    for (int k = 0; k < 8; k++)
      for (int l = 0; l < 8; l++)
        step("R1", 0, k, l, 0);
    step("R6", 0, 3, 3, 0);

    // R2/R3/R9: lockout sequence for every allowance
    for (int n = 0; n < 8; n++) begin
      doReset();
      for (int i = 0; i < ((n == 0) ? 1 : n); i++)
        step((n == 0) ? "R3" : "R2", 1, 2, 5, n);
      step("R9", 0, 4, 4, n);
      // R4: correct strobed key after lockout does nothing
      step("R4", 1, 4, 4, n);
      step("R4", 1, 6, 6, 7);
      step("R4", 0, 6, 6, 7);
    end

    // R5: correct attempt re-arms full allowance
    doReset();
    step("R5", 1, 1, 2, 3);
    step("R5", 1, 1, 2, 3);
    step("R5", 1, 7, 7, 3);
    step("R5", 1, 0, 5, 3);
    step("R5", 1, 0, 5, 3);
    step("R5", 0, 5, 5, 3);
    step("R5", 1, 0, 5, 3);
    step("R5", 0, 5, 5, 3);

    // R8: allowance lowered mid-run
    doReset();
    step("R8", 1, 1, 6, 5);
    step("R8", 1, 1, 6, 5);
    step("R8", 1, 1, 6, 5);
    step("R8", 0, 1, 1, 2);
    step("R8", 1, 1, 6, 2);
    step("R8", 0, 1, 1, 2);

    // R7: reset after lockout clears it
    doReset();
    step("R7", 0, 3, 3, 0);
    step("R7", 1, 3, 3, 0);
    step("R7", 0, 3, 3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule